// File: doc/BRIEF.md
# Color Bar Test Pattern Source

This block produces an endless series of synthetic video frames on a valid/ready streaming output that marks packet boundaries with start and end flags. Each frame is a short control packet that announces the frame geometry, followed by a video packet that carries the pixels in raster order, one pixel per beat with three 8-bit color planes side by side.

The picture is either eight vertical bars at 75% amplitude or a flat field whose three plane values come from registers. Bars can be coded as R'G'B' or as Y'CbCr. A small write-only register port sets a run bit, the frame size, the pattern, the color space and the flat-field values. Geometry, pattern, color space and flat-field values are captured only when a frame begins, so software may rewrite them at any time without tearing a frame in progress.

Top module: `cbar_gen`

## Requirements
- R1: After reset `src_valid` is low, and it stays low until the run bit (register 0, bit 0) is written to 1.
- R2: Each frame opens with a three-beat control packet. Beat 1 has `src_sop` set and the type code 4'hF in data[3:0]. Beat 2 carries the width in data[15:0]. Beat 3 carries the height in data[15:0] and has `src_eop` set. Unused data bits are 0.
- R3: The control packet is followed by a video packet. Its first beat has `src_sop` set and data equal to 0, which is type code 4'h0. Then come width×height pixel beats in raster order, with `src_eop` set on the last one only.
- R4: Pixels are packed with plane 0 (R or Y') in data[7:0], plane 1 (G or Cb) in data[15:8] and plane 2 (B or Cr) in data[23:16]. In bar mode with R'G'B' coding (register 3 bit 1 = 0), bars 0 to 7 are white, yellow, cyan, green, magenta, red, blue and black. A component that is on is 180 and a component that is off is 16.
- R5: With Y'CbCr coding (register 3 bit 1 = 1), the bars as (Y',Cb,Cr) are white (180,128,128), yellow (162,44,142), cyan (131,156,44), green (112,72,58), magenta (84,184,198), red (65,100,212), blue (35,212,114) and black (16,128,128).
- R6: Every bar is floor(width/8) pixels wide, and the last bar also takes the remaining pixels. When the width is below 8, every pixel of the line belongs to the black bar.
- R7: With register 3 bit 0 = 1 (flat field), every pixel equals {reg6[7:0], reg5[7:0], reg4[7:0]}.
- R8: Width (register 1), height (register 2), pattern, color space and flat-field values are captured when a frame starts. Writes made during a frame take effect only from the next frame.
- R9: While `src_valid` is high and `src_ready` is low, `src_valid`, `src_data`, `src_sop` and `src_eop` hold their values.
- R10: The run bit is checked at the end of each video packet. If it is set, the next control packet follows at once. If it is clear, the output goes idle and the control and video packets keep alternating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index (0 run, 1 width, 2 height, 3 mode, 4..6 plane values) |
| cfg_wdata | input | DIM_W (16) | Register write data |
| src_ready | input | 1 | Sink can accept a beat |
| src_valid | output | 1 | Beat present on the output |
| src_sop | output | 1 | First beat of a packet |
| src_eop | output | 1 | Last beat of a packet |
| src_data | output | 24 | Header word or pixel, three 8-bit planes |

## Verification
A beat counts as transferred on the rising edge where `src_valid` and `src_ready` are both high. The bench changes `src_ready` on the falling edge and samples one time step later, so it logs exactly the beats that transfer on the next rising edge. It then checks them, in order, against frames computed from the requirements. A register write takes effect on the edge that follows the strobe. The bench clears the run bit only after the first beat of a frame has been seen, which leaves at least two beats of margin before the end-of-packet decision. The stall checks compare each held beat with the beat sampled one cycle earlier.

// File: rtl/cbar_pkg.sv
package cbar_pkg;
  localparam int PLANE_W  = 8;
  localparam int PLANES   = 3;
  localparam int DATA_W   = PLANE_W * PLANES;
  localparam int BAR_W    = 3;
  localparam logic [PLANE_W-1:0] LVL_OFF = 8'd16;
  localparam logic [PLANE_W-1:0] LVL_ON  = 8'd180;
  localparam logic [3:0] TYPE_CTRL = 4'hF;
  localparam logic [3:0] TYPE_VID  = 4'h0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHDR, ST_CWID, ST_CHGT, ST_VHDR, ST_VPIX
  } seq_st_e;

  typedef struct packed {
    logic flat;
    logic ycc;
  } mode_t;

  // Bar index to packed pixel {p2,p1,p0}
  function automatic logic [DATA_W-1:0] bar_color(input logic [BAR_W-1:0] b,
                                                  input logic ycc);
    logic [PLANE_W-1:0] r, g, bl;
    logic [DATA_W-1:0]  c;
    r  = b[1] ? LVL_OFF : LVL_ON;
    g  = b[2] ? LVL_OFF : LVL_ON;
    bl = b[0] ? LVL_OFF : LVL_ON;
    c  = {bl, g, r};
    if (ycc) begin
      case (b)
        3'd0:    c = {8'd128, 8'd128, 8'd180};
        3'd1:    c = {8'd142, 8'd44,  8'd162};
        3'd2:    c = {8'd44,  8'd156, 8'd131};
        3'd3:    c = {8'd58,  8'd72,  8'd112};
        3'd4:    c = {8'd198, 8'd184, 8'd84};
        3'd5:    c = {8'd212, 8'd100, 8'd65};
        3'd6:    c = {8'd114, 8'd212, 8'd35};
        default: c = {8'd128, 8'd128, 8'd16};
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/cbar_regs.sv
module cbar_regs
  import cbar_pkg::*;
#(
  parameter int DIM_W = 16,
  parameter int DEF_W = 16,
  parameter int DEF_H = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [2:0]          addr,
  input  logic [DIM_W-1:0]    wdata,
  output logic                run,
  output logic [DIM_W-1:0]    width,
  output logic [DIM_W-1:0]    height,
  output mode_t               mode,
  output logic [DATA_W-1:0]   planes
);
  logic                run_n;
  logic [DIM_W-1:0]    width_n, height_n;
  mode_t               mode_n;
  logic [DATA_W-1:0]   planes_n;

  always_comb begin
    run_n    = run;
    width_n  = width;
    height_n = height;
    mode_n   = mode;
    planes_n = planes;
    if (wr) begin
      case (addr)
        3'd0: run_n    = wdata[0];
        3'd1: width_n  = wdata;
        3'd2: height_n = wdata;
        3'd3: mode_n   = '{flat: wdata[0], ycc: wdata[1]};
        3'd4: planes_n[0*PLANE_W +: PLANE_W] = wdata[PLANE_W-1:0];
        3'd5: planes_n[1*PLANE_W +: PLANE_W] = wdata[PLANE_W-1:0];
        3'd6: planes_n[2*PLANE_W +: PLANE_W] = wdata[PLANE_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      width  <= DIM_W'(DEF_W);
      height <= DIM_W'(DEF_H);
      mode   <= '0;
      planes <= '0;
    end else begin
      run    <= run_n;
      width  <= width_n;
      height <= height_n;
      mode   <= mode_n;
      planes <= planes_n;
    end
  end
endmodule

// File: rtl/cbar_barpos.sv
module cbar_barpos
  import cbar_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic              line_end,
  input  logic [DIM_W-1:0]  bar_len,
  output logic [BAR_W-1:0]  bar
);
  localparam logic [BAR_W-1:0] LAST_BAR = '1;

  logic [DIM_W-1:0] pos, pos_n;
  logic [BAR_W-1:0] bar_n;
  logic [BAR_W-1:0] first_bar;

  assign first_bar = (bar_len == '0) ? LAST_BAR : '0;

  always_comb begin
    bar_n = bar;
    pos_n = pos;
    if (start || (step && line_end)) begin
      bar_n = first_bar;
      pos_n = '0;
    end else if (step && (bar != LAST_BAR)) begin
      if (pos == bar_len - 1'b1) begin
        bar_n = bar + 1'b1;
        pos_n = '0;
      end else begin
        pos_n = pos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bar <= '0;
      pos <= '0;
    end else begin
      bar <= bar_n;
      pos <= pos_n;
    end
  end
endmodule

// File: rtl/cbar_seq.sv
module cbar_seq
  import cbar_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [DIM_W-1:0]   width,
  input  logic [DIM_W-1:0]   height,
  input  mode_t              mode,
  input  logic [DATA_W-1:0]  planes,
  input  logic [BAR_W-1:0]   bar,
  input  logic               ready,
  output logic               valid,
  output logic               sop,
  output logic               eop,
  output logic [DATA_W-1:0]  data,
  output logic               bar_start,
  output logic               bar_step,
  output logic               line_end,
  output logic [DIM_W-1:0]   bar_len
);
  seq_st_e            st, st_n;
  logic [DIM_W-1:0]   col, col_n, row, row_n;
  logic [DIM_W-1:0]   w_l, h_l;
  mode_t              mode_l;
  logic [DATA_W-1:0]  planes_l;
  logic               fire, last_pix, load;

  assign valid     = (st != ST_IDLE);
  assign fire      = valid && ready;
  assign line_end  = (col == w_l - 1'b1);
  assign last_pix  = line_end && (row == h_l - 1'b1);
  assign bar_len   = w_l >> BAR_W;
  assign bar_start = (st == ST_VHDR) && fire;
  assign bar_step  = (st == ST_VPIX) && fire;
  assign load      = run && ((st == ST_IDLE) || (bar_step && last_pix));
  assign sop       = (st == ST_CHDR) || (st == ST_VHDR);
  assign eop       = (st == ST_CHGT) || ((st == ST_VPIX) && last_pix);

  always_comb begin
    case (st)
      ST_CHDR: data = DATA_W'(TYPE_CTRL);
      ST_CWID: data = DATA_W'(w_l);
      ST_CHGT: data = DATA_W'(h_l);
      ST_VPIX: data = mode_l.flat ? planes_l : bar_color(bar, mode_l.ycc);
      default: data = '0;
    endcase
  end

  always_comb begin
    st_n  = st;
    col_n = col;
    row_n = row;
    case (st)
      ST_IDLE: if (run) st_n = ST_CHDR;
      ST_CHDR: if (fire) st_n = ST_CWID;
      ST_CWID: if (fire) st_n = ST_CHGT;
      ST_CHGT: if (fire) st_n = ST_VHDR;
      ST_VHDR: if (fire) begin
        st_n  = ST_VPIX;
        col_n = '0;
        row_n = '0;
      end
      ST_VPIX: if (fire) begin
        if (last_pix) begin
          st_n = run ? ST_CHDR : ST_IDLE;
        end else if (line_end) begin
          col_n = '0;
          row_n = row + 1'b1;
        end else begin
          col_n = col + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      col <= '0;
      row <= '0;
    end else begin
      st  <= st_n;
      col <= col_n;
      row <= row_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_l      <= '0;
      h_l      <= '0;
      mode_l   <= '0;
      planes_l <= '0;
    end else if (load) begin
      w_l      <= width;
      h_l      <= height;
      mode_l   <= mode;
      planes_l <= planes;
    end
  end
endmodule

// File: rtl/cbar_gen.sv
module cbar_gen
  import cbar_pkg::*;
#(
  parameter int DIM_W = 16,
  parameter int DEF_W = 16,
  parameter int DEF_H = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [2:0]         cfg_addr,
  input  logic [DIM_W-1:0]   cfg_wdata,
  input  logic               src_ready,
  output logic               src_valid,
  output logic               src_sop,
  output logic               src_eop,
  output logic [DATA_W-1:0]  src_data
);
  logic [1:0]         rst_sync;
  logic               rst_int_n;
  logic               run;
  logic [DIM_W-1:0]   width, height, bar_len;
  mode_t              mode;
  logic [DATA_W-1:0]  planes;
  logic [BAR_W-1:0]   bar;
  logic               bar_start, bar_step, line_end;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  cbar_regs #(.DIM_W(DIM_W), .DEF_W(DEF_W), .DEF_H(DEF_H)) regs_i (
    .clk(clk), .rst_n(rst_int_n), .wr(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .run(run), .width(width), .height(height),
    .mode(mode), .planes(planes)
  );

  cbar_seq #(.DIM_W(DIM_W)) seq_i (
    .clk(clk), .rst_n(rst_int_n), .run(run), .width(width),
    .height(height), .mode(mode), .planes(planes), .bar(bar),
    .ready(src_ready), .valid(src_valid), .sop(src_sop), .eop(src_eop),
    .data(src_data), .bar_start(bar_start), .bar_step(bar_step),
    .line_end(line_end), .bar_len(bar_len)
  );

  cbar_barpos #(.DIM_W(DIM_W)) barpos_i (
    .clk(clk), .rst_n(rst_int_n), .start(bar_start), .step(bar_step),
    .line_end(line_end), .bar_len(bar_len), .bar(bar)
  );
endmodule

// File: rtl/cbar_gen_chk.sv
module cbar_gen_chk
  import cbar_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               src_ready,
  input logic               src_valid,
  input logic               src_sop,
  input logic               src_eop,
  input logic [DATA_W-1:0]  src_data
);
  logic fire, in_pkt, last_ctrl;
  assign fire = src_valid && src_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt    <= 1'b0;
      last_ctrl <= 1'b0;
    end else if (fire) begin
      if (src_eop)      in_pkt <= 1'b0;
      else if (src_sop) in_pkt <= 1'b1;
      if (src_sop)      last_ctrl <= (src_data[3:0] == TYPE_CTRL);
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && !src_ready |=> src_valid && $stable(src_data)
      && $stable(src_sop) && $stable(src_eop));

  // R2
  pkt_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && !in_pkt |-> src_sop &&
      (src_data[3:0] == TYPE_CTRL || src_data[3:0] == TYPE_VID));

  // R3
  no_inner_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && in_pkt |-> !src_sop);

  // R10
  alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && src_sop && !in_pkt |->
      ((src_data[3:0] == TYPE_VID) == last_ctrl));

  // R1
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_valid) |-> src_sop && src_data[3:0] == TYPE_CTRL);
endmodule

bind cbar_gen cbar_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .src_ready(src_ready), .src_valid(src_valid),
  .src_sop(src_sop), .src_eop(src_eop), .src_data(src_data)
);

// File: tb/cbar_gen_tb_top.sv
module cbar_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        src_ready = 1'b0;
  logic        src_valid, src_sop, src_eop;
  logic [23:0] src_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [25:0] beats[$];
  logic [7:0]  lfsr = 8'h5A;
  logic        held = 1'b0;
  logic [25:0] held_beat = '0;

  always #5 clk = ~clk;

  cbar_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .src_ready(src_ready), .src_valid(src_valid),
    .src_sop(src_sop), .src_eop(src_eop), .src_data(src_data)
  );

  task automatic check(input string req, input logic [25:0] got,
                       input logic [25:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // ready changes at the falling edge; logged beats transfer at the next rise
  always begin
    @(negedge clk);
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    src_ready <= lfsr[0] | lfsr[2];
    #1;
    if (held) check("R9 stall hold", {src_valid, src_sop, src_eop, src_data[22:0]},
                    {1'b1, held_beat[25:24], held_beat[22:0]});
    held = src_valid && !src_ready;
    held_beat = {src_sop, src_eop, src_data};
    if (src_valid && src_ready) beats.push_back({src_sop, src_eop, src_data});
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  function automatic logic [23:0] exp_pix(input int w, input int col,
      input bit flat, input bit ycc, input logic [23:0] pl);
    int b;
    logic [7:0] r, g, bl;
    if (flat) return pl;
    if (w / 8 == 0) b = 7;
    else begin
      b = col / (w / 8);
      if (b > 7) b = 7;
    end
    if (ycc) begin
      case (b)
        0: return {8'd128, 8'd128, 8'd180};
        1: return {8'd142, 8'd44, 8'd162};
        2: return {8'd44, 8'd156, 8'd131};
        3: return {8'd58, 8'd72, 8'd112};
        4: return {8'd198, 8'd184, 8'd84};
        5: return {8'd212, 8'd100, 8'd65};
        6: return {8'd114, 8'd212, 8'd35};
        default: return {8'd128, 8'd128, 8'd16};
      endcase
    end
    // white, yellow, cyan, green, magenta, red, blue, black
    r  = (b == 0 || b == 1 || b == 4 || b == 5) ? 8'd180 : 8'd16;
    g  = (b <= 3) ? 8'd180 : 8'd16;
    bl = (b % 2 == 0) ? 8'd180 : 8'd16;
    return {bl, g, r};
  endfunction

  task automatic check_frame(input int w, input int h, input bit flat,
      input bit ycc, input logic [23:0] pl);
    logic [25:0] bt;
    string req;
    while (beats.size() < 4 + w * h) @(negedge clk);
    bt = beats.pop_front(); check("R2 ctrl header", bt, {2'b10, 24'h00000F});
    bt = beats.pop_front(); check("R2 ctrl width",  bt, {2'b00, 8'h0, 16'(w)});
    bt = beats.pop_front(); check("R2 ctrl height", bt, {2'b01, 8'h0, 16'(h)});
    bt = beats.pop_front(); check("R3 video header", bt, {2'b10, 24'h0});
    req = flat ? "R7 flat pixel" : (ycc ? "R5 R6 ycc bar" : "R4 R6 rgb bar");
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        bt = beats.pop_front();
        check(req, bt, {1'b0, (y == h - 1 && x == w - 1),
                        exp_pix(w, x, flat, ycc, pl)});
      end
  endtask

  task automatic expect_idle(input string req);
    bit seen = 0;
    repeat (20) begin @(negedge clk); #2; if (src_valid) seen = 1; end
    check(req, {25'd0, seen}, 26'd0);
    check(req, 26'(beats.size()), 26'd0);
  endtask

  task automatic one_frame(input int w, input int h, input bit flat,
      input bit ycc, input logic [23:0] pl);
    wr(3'd1, 16'(w)); wr(3'd2, 16'(h)); wr(3'd3, {14'd0, ycc, flat});
    wr(3'd4, {8'd0, pl[7:0]}); wr(3'd5, {8'd0, pl[15:8]});
    wr(3'd6, {8'd0, pl[23:16]});
    wr(3'd0, 16'd1);
    while (beats.size() == 0) @(negedge clk);
    wr(3'd0, 16'd0);
    check_frame(w, h, flat, ycc, pl);
    expect_idle("R10 stop after frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_idle("R1 idle after reset");

    // R8: mid-frame writes only reach the next frame
    wr(3'd1, 16'd16); wr(3'd2, 16'd3); wr(3'd3, 16'd0); wr(3'd0, 16'd1);
    while (beats.size() == 0) @(negedge clk);
    wr(3'd1, 16'd7); wr(3'd3, 16'd1); wr(3'd0, 16'd0);
    check_frame(16, 3, 0, 0, 24'h0);
    expect_idle("R8 R10 idle");

    one_frame(19, 2, 0, 1, 24'h0);
    one_frame(5, 2, 0, 0, 24'h0);
    one_frame(4, 2, 1, 0, 24'h332211);
    one_frame(3, 3, 1, 1, 24'hF0A50C);

    // R10 back-to-back frames, second picks up new width (R8)
    wr(3'd1, 16'd8); wr(3'd2, 16'd1); wr(3'd3, 16'd2); wr(3'd0, 16'd1);
    while (beats.size() == 0) @(negedge clk);
    wr(3'd1, 16'd12);
    while (beats.size() < 13) @(negedge clk);
    wr(3'd0, 16'd0);
    check_frame(8, 1, 0, 1, 24'h0);
    check_frame(12, 1, 0, 1, 24'h0);
    expect_idle("R10 idle after pair");

    // R6 width sweep, both codings
    for (int w = 1; w <= 26; w++) one_frame(w, 1, 0, w % 2, 24'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule